// File: doc/BRIEF.md
# Serial ADC Register and Conversion Sequencer

This block is a serial-port master for an ADC. The ADC has a 22-bit command/data port, a convert-start line and a ready line. On the user side there is a single-cycle request with an operation select, a register address and write data. The block answers each accepted request with a one-cycle completion pulse. Register reads are returned as a byte. Conversion results are returned as a full 22-bit word.

Each operation is a short sequence of serial frames:
- **Write.** A write sends one frame.
- **Read.** A read sends a read frame, then an all-zero frame. The register byte arrives at the start of the all-zero frame.
- **Conversion.** A conversion first pulses the convert line high for a fixed number of system cycles. It then waits for the synchronised ready input. It then clocks an all-zero frame and keeps everything shifted in. If ready never comes, a cycle budget ends the wait and raises an error flag.

The sequencer states are:

| State | Role | Leaves when | Goes to |
|---|---|---|---|
| `ST_IDLE` | waiting for a request | a write, read or conversion request is accepted | `ST_WR_SEND`, `ST_RD_SEND` or `ST_CV_HIGH` |
| `ST_WR_SEND` | write frame in flight | frame ends | `ST_TAIL` |
| `ST_RD_SEND` | read frame in flight | frame ends | `ST_RD_GAP` |
| `ST_RD_GAP` | deselect spacing | `CS_GAP` cycles have passed | `ST_RD_NOP` |
| `ST_RD_NOP` | zero frame that returns the byte | frame ends | `ST_TAIL` |
| `ST_CV_HIGH` | convert line high | `CONV_HI` cycles have passed | `ST_CV_WAIT` |
| `ST_CV_WAIT` | waiting for synchronised ready | ready seen | `ST_CV_NOP` |
| | | budget of `TIMEOUT` cycles spent | `ST_TAIL` (error) |
| `ST_CV_NOP` | zero frame that returns the conversion word | frame ends | `ST_TAIL` |
| `ST_TAIL` | deselect spacing; completion pulse on its last cycle | `CS_GAP` cycles have passed | `ST_IDLE` |

Top module: `adc_serial_ctrl`

## Requirements
- R1: A write request sends exactly one 22-bit frame, MSB first, made of opcode 5'b10010, then the 9-bit address, then the 8-bit data.
- R2: A read request sends the frame {5'b10001, address, 8'h00} and then a frame of 22 zero bits. `rd_data` becomes the first 8 bits received during the zero frame, with the first bit as bit 7.
- R3: While chip select is high, SCLK is low. MOSI never changes while SCLK is high, so it changes only at falling edges. Every frame holds chip select low for exactly 22×`CLK_DIV` system cycles and carries 22 rising SCLK edges. MISO is sampled on the rising edges.
- R4: Between any two frames, chip select stays high for at least `CS_GAP` system cycles.
- R5: A conversion request drives CONVST high for exactly `CONV_HI` system cycles. No frame is active while CONVST is high.
- R6: During a conversion, the frame starts only after the ready input is high. Chip select falls on the third system clock edge after ready rises, because of two synchronising flops. That frame sends 22 zero bits. `conv_data` then holds all 22 received bits, with the first bit as bit 21.
- R7: If ready stays low for `TIMEOUT` cycles after CONVST falls, then no frame is sent, `timeout_err` goes high and `done` still pulses. `timeout_err` clears when the next request is accepted.
- R8: `busy` is high from the cycle after a request is accepted until the cycle after `done`. `done` lasts one cycle. A request raised while `busy` is ignored. `rd_data` and `conv_data` change only when their own operation completes.
- R9: After reset: chip select is high, SCLK, CONVST, `busy`, `done` and `timeout_err` are low, and `rd_data` and `conv_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req | input | 1 | request strobe, taken only when idle |
| req_op | input | 2 | operation: 0 write, 1 read, 2 conversion, 3 ignored |
| req_addr | input | 9 | register address |
| req_wdata | input | 8 | register write data |
| busy | output | 1 | sequence in progress |
| done | output | 1 | one-cycle completion pulse |
| rd_data | output | 8 | last register byte read |
| conv_data | output | 22 | last conversion word |
| timeout_err | output | 1 | last conversion ended without ready |
| adc_sclk | output | 1 | serial clock, idle low |
| adc_cs_n | output | 1 | active-low chip select |
| adc_mosi | output | 1 | serial data to the ADC |
| adc_miso | input | 1 | serial data from the ADC |
| adc_convst | output | 1 | convert-start pulse |
| adc_ready | input | 1 | conversion-ready indication from the ADC |

## Verification
The properties assume three things about the ADC side:
- It changes MISO only while SCLK is low.
- It raises ready only after the convert pulse has ended.
- It keeps ready high until the next convert pulse starts.

The bench's ADC model meets all three. It updates MISO only at falling SCLK edges it observes or when chip select falls, and it drops ready when CONVST rises. Requests are issued only from idle, except for one deliberate pulse during a busy read. That pulse is dropped before `done`, so the property that `busy` falls after `done` is never blurred by a back-to-back request.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    localparam int FRAME_W = 22;
    localparam int OPC_W   = 5;
    localparam int ADR_W   = 9;
    localparam int DAT_W   = 8;

    localparam logic [OPC_W-1:0] OPC_WRITE = 5'b10010;
    localparam logic [OPC_W-1:0] OPC_READ  = 5'b10001;

    typedef enum logic [1:0] {
        REQ_WRITE = 2'd0,
        REQ_READ  = 2'd1,
        REQ_CONV  = 2'd2
    } req_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_SEND,
        ST_RD_SEND,
        ST_RD_GAP,
        ST_RD_NOP,
        ST_CV_HIGH,
        ST_CV_WAIT,
        ST_CV_NOP,
        ST_TAIL
    } seq_state_e;

endpackage

// File: rtl/adc_ready_sync.sv
module adc_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= {sr_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
    parameter int CLK_DIV = 4,
    parameter int FRAME_W = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               miso,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    output logic [FRAME_W-1:0] rx_word,
    output logic               frame_done
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int PH_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(FRAME_W);

    logic               active_q;
    logic [PH_W-1:0]    ph_q;
    logic [BIT_W-1:0]   bit_q;
    logic [FRAME_W-1:0] tx_q;
    logic [FRAME_W-1:0] rx_q;
    logic               done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            ph_q     <= '0;
            bit_q    <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (start) begin
                    active_q <= 1'b1;
                    ph_q     <= '0;
                    bit_q    <= '0;
                    tx_q     <= tx_word;
                end
            end else begin
                // rising SCLK edge happens as the phase enters the high half
                if (ph_q == PH_W'(HALF - 1))
                    rx_q <= {rx_q[FRAME_W-2:0], miso};
                if (ph_q == PH_W'(CLK_DIV - 1)) begin
                    ph_q <= '0;
                    if (bit_q == BIT_W'(FRAME_W - 1)) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        bit_q <= bit_q + BIT_W'(1);
                        tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
                    end
                end else begin
                    ph_q <= ph_q + PH_W'(1);
                end
            end
        end
    end

    assign sclk       = active_q && (ph_q >= PH_W'(HALF));
    assign cs_n       = !active_q;
    assign mosi       = active_q && tx_q[FRAME_W-1];
    assign rx_word    = rx_q;
    assign frame_done = done_q;
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int CONV_HI     = 6,
    parameter int CS_GAP      = 2,
    parameter int TIMEOUT     = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [1:0]          req_op,
    input  logic [ADR_W-1:0]    req_addr,
    input  logic [DAT_W-1:0]    req_wdata,
    output logic                busy,
    output logic                done,
    output logic [DAT_W-1:0]    rd_data,
    output logic [FRAME_W-1:0]  conv_data,
    output logic                timeout_err,
    output logic                adc_sclk,
    output logic                adc_cs_n,
    output logic                adc_mosi,
    input  logic                adc_miso,
    output logic                adc_convst,
    input  logic                adc_ready
);
    localparam int CNT_W = $clog2(TIMEOUT + CONV_HI + CS_GAP + 1);

    seq_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic                rdy_s;
    logic                fr_start;
    logic [FRAME_W-1:0]  fr_word;
    logic [FRAME_W-1:0]  fr_rx;
    logic                fr_done;
    logic                gap_end, hi_end, wait_end;
    logic                accept;
    logic [DAT_W-1:0]    rd_q;
    logic [FRAME_W-1:0]  conv_q;
    logic                err_q;

    adc_ready_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (adc_ready),
        .dout  (rdy_s)
    );

    adc_frame_shifter #(.CLK_DIV(CLK_DIV), .FRAME_W(FRAME_W)) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fr_start),
        .tx_word    (fr_word),
        .miso       (adc_miso),
        .sclk       (adc_sclk),
        .cs_n       (adc_cs_n),
        .mosi       (adc_mosi),
        .rx_word    (fr_rx),
        .frame_done (fr_done)
    );

    assign gap_end  = (cnt_q == CNT_W'(CS_GAP - 1));
    assign hi_end   = (cnt_q == CNT_W'(CONV_HI - 1));
    assign wait_end = (cnt_q == CNT_W'(TIMEOUT - 1));
    assign accept   = (state_q == ST_IDLE) && req && (req_op != 2'd3);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    case (req_op)
                        REQ_WRITE: state_d = ST_WR_SEND;
                        REQ_READ:  state_d = ST_RD_SEND;
                        REQ_CONV:  state_d = ST_CV_HIGH;
                        default:   state_d = ST_IDLE;
                    endcase
                end
            end
            ST_WR_SEND: if (fr_done) state_d = ST_TAIL;
            ST_RD_SEND: if (fr_done) state_d = ST_RD_GAP;
            ST_RD_GAP:  if (gap_end) state_d = ST_RD_NOP;
            ST_RD_NOP:  if (fr_done) state_d = ST_TAIL;
            ST_CV_HIGH: if (hi_end)  state_d = ST_CV_WAIT;
            ST_CV_WAIT: begin
                if (rdy_s)         state_d = ST_CV_NOP;
                else if (wait_end) state_d = ST_TAIL;
            end
            ST_CV_NOP:  if (fr_done) state_d = ST_TAIL;
            ST_TAIL:    if (gap_end) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and dwell counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || state_q == ST_IDLE) cnt_q <= '0;
            else                                          cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        fr_start   = 1'b0;
        fr_word    = '0;
        adc_convst = 1'b0;
        done       = 1'b0;
        busy       = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: begin
                if (req && req_op == REQ_WRITE) begin
                    fr_start = 1'b1;
                    fr_word  = {OPC_WRITE, req_addr, req_wdata};
                end else if (req && req_op == REQ_READ) begin
                    fr_start = 1'b1;
                    fr_word  = {OPC_READ, req_addr, DAT_W'(0)};
                end
            end
            ST_RD_GAP:  fr_start   = gap_end;
            ST_CV_HIGH: adc_convst = 1'b1;
            ST_CV_WAIT: fr_start   = rdy_s;
            ST_TAIL:    done       = gap_end;
            default: ;
        endcase
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= '0;
            conv_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (accept) err_q <= 1'b0;
            if (state_q == ST_CV_WAIT && !rdy_s && wait_end) err_q <= 1'b1;
            if (state_q == ST_RD_NOP && fr_done) rd_q <= fr_rx[FRAME_W-1 -: DAT_W];
            if (state_q == ST_CV_NOP && fr_done) conv_q <= fr_rx;
        end
    end

    assign rd_data     = rd_q;
    assign conv_data   = conv_q;
    assign timeout_err = err_q;
endmodule

// File: rtl/adc_serial_ctrl_chk.sv
module adc_serial_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic timeout_err,
    input logic adc_sclk,
    input logic adc_cs_n,
    input logic adc_mosi,
    input logic adc_convst
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk); // R3
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sclk && $past(adc_sclk)) |-> $stable(adc_mosi)); // R3
    AST_CS_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |=> adc_cs_n); // R4
    AST_CONVST_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convst |-> (adc_cs_n && busy)); // R5
    AST_TIMEOUT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> adc_cs_n); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R8
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R8
endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .adc_sclk    (adc_sclk),
    .adc_cs_n    (adc_cs_n),
    .adc_mosi    (adc_mosi),
    .adc_convst  (adc_convst)
);

// File: tb/adc_serial_ctrl_tb_top.sv
module adc_serial_ctrl_tb_top;
    localparam int CLK_DIV = 4;
    localparam int CONV_HI = 6;
    localparam int CS_GAP  = 2;
    localparam int TMO     = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [8:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, timeout_err;
    logic [7:0]  rd_data;
    logic [21:0] conv_data;
    logic        adc_sclk, adc_cs_n, adc_mosi, adc_convst;
    logic        adc_miso = 1'b0;
    logic        adc_ready = 1'b0;

    always #10 clk = ~clk;

    adc_serial_ctrl #(.CLK_DIV(CLK_DIV), .CONV_HI(CONV_HI), .CS_GAP(CS_GAP),
                      .TIMEOUT(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .conv_data(conv_data), .timeout_err(timeout_err),
        .adc_sclk(adc_sclk), .adc_cs_n(adc_cs_n), .adc_mosi(adc_mosi),
        .adc_miso(adc_miso), .adc_convst(adc_convst), .adc_ready(adc_ready)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // behavioural ADC model and per-clock comparisons
    logic [21:0] exp_q[$];
    logic [7:0]  regs [0:511];
    logic [21:0] sh_in = '0, resp = '0, conv_word = '0;
    int  in_cnt = 0, out_idx = 0, low_cyc = 0, high_cyc = 0, frames = 0;
    int  cyc = 0, conv_hi = 0, rdy_cnt = 0, rdy_delay = 0, rdy_t = 0;
    bit  armed = 0, seen = 0, conv_frame = 0;
    logic p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0, p_cv = 1'b0;

    initial for (int i = 0; i < 512; i++) regs[i] = 8'h00;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(!(adc_cs_n && adc_sclk), "R3 sclk idle", adc_sclk, 0);
            if (adc_sclk && p_sclk)
                chk(adc_mosi == p_mosi, "R3 mosi hold", adc_mosi, p_mosi);
            if (p_cs && !adc_cs_n) begin
                if (seen) chk(high_cyc >= CS_GAP, "R4 gap", high_cyc, CS_GAP);
                if (conv_frame) begin
                    chk(cyc - rdy_t == 3, "R6 ready latency", cyc - rdy_t, 3);
                    conv_frame = 0;
                end
                sh_in = '0; in_cnt = 0; low_cyc = 0; out_idx = 21;
                adc_miso = resp[21];
            end
            if (!adc_cs_n) begin
                low_cyc++;
                if (adc_sclk && !p_sclk) begin
                    sh_in = {sh_in[20:0], adc_mosi};
                    in_cnt++;
                end
                if (!adc_sclk && p_sclk) begin
                    out_idx--;
                    if (out_idx >= 0) adc_miso = resp[out_idx];
                end
            end
            if (!p_cs && adc_cs_n) begin
                chk(in_cnt == 22, "R3 edges", in_cnt, 22);
                chk(low_cyc == 22 * CLK_DIV, "R3 cs low", low_cyc, 22 * CLK_DIV);
                if (exp_q.size() == 0) chk(0, "R8 unexpected frame", sh_in, 0);
                else begin
                    logic [21:0] e;
                    e = exp_q.pop_front();
                    chk(sh_in == e, "R1/R2 frame", sh_in, e);
                end
                if (sh_in[21:17] == 5'b10010) regs[sh_in[16:8]] = sh_in[7:0];
                resp = (sh_in[21:17] == 5'b10001) ? {regs[sh_in[16:8]], 14'b0} : 22'b0;
                adc_miso = 1'b0;
                high_cyc = 0; seen = 1; frames++;
            end
            if (adc_cs_n) high_cyc++;
            if (adc_convst) begin conv_hi++; adc_ready = 1'b0; end
            if (p_cv && !adc_convst) begin
                chk(conv_hi == CONV_HI, "R5 convst width", conv_hi, CONV_HI);
                conv_hi = 0;
                if (rdy_delay >= 0) begin armed = 1; rdy_cnt = rdy_delay; end
            end
            if (armed) begin
                if (rdy_cnt == 0) begin
                    adc_ready = 1'b1; resp = conv_word; armed = 0;
                    rdy_t = cyc; conv_frame = 1;
                end else rdy_cnt--;
            end
        end
        p_cs = adc_cs_n; p_sclk = adc_sclk; p_mosi = adc_mosi; p_cv = adc_convst;
    end

    task automatic issue(input logic [1:0] op, input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        req = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        chk(busy, "R8 busy after accept", busy, 1);
    endtask

    task automatic finish_seq();
        int dn = 0;
        int w = 0;
        while (busy && w < 5000) begin
            if (done) dn++;
            @(negedge clk);
            w++;
        end
        chk(w < 5000, "R8 completion", w, 0);
        chk(dn == 1, "R8 done pulse", dn, 1);
    endtask

    task automatic do_write(input logic [8:0] a, input logic [7:0] d);
        exp_q.push_back({5'b10010, a, d});
        issue(2'd0, a, d);
        finish_seq();
    endtask

    task automatic do_read(input logic [8:0] a, input logic [7:0] expv);
        exp_q.push_back({5'b10001, a, 8'h00});
        exp_q.push_back(22'h0);
        issue(2'd1, a, 8'h00);
        finish_seq();
        chk(rd_data == expv, "R2 read byte", rd_data, expv);
    endtask

    task automatic do_conv(input logic [21:0] w, input int dly);
        conv_word = w; rdy_delay = dly;
        if (dly >= 0) exp_q.push_back(22'h0);
        issue(2'd2, 9'h0, 8'h00);
        finish_seq();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(adc_cs_n && !adc_sclk && !adc_convst, "R9 pins idle", {adc_cs_n, adc_sclk, adc_convst}, 3'b100);
        chk(!busy && !done && !timeout_err, "R9 flags", {busy, done, timeout_err}, 0);
        chk(rd_data == 0 && conv_data == 0, "R9 data", conv_data, 0);

        do_write(9'h010, 8'h0F);              // R1 frame 0x24100F
        do_read(9'h010, 8'h0F);               // R2
        do_write(9'h1FF, 8'hA5);              // R1 top address
        do_write(9'h000, 8'h80);              // R1 MSB data
        do_read(9'h1FF, 8'hA5);               // R2
        do_read(9'h000, 8'h80);               // R2
        do_read(9'h123, 8'h00);               // R2 unwritten

        do_conv(22'h2AAAAA, 10);              // R5 R6
        chk(conv_data == 22'h2AAAAA, "R6 conv word", conv_data, 22'h2AAAAA);
        chk(rd_data == 8'h00, "R8 rd hold", rd_data, 0);
        chk(!timeout_err, "R7 no error", timeout_err, 0);
        do_conv(22'h15B3C9, 3);               // R6
        chk(conv_data == 22'h15B3C9, "R6 conv word 2", conv_data, 22'h15B3C9);

        begin
            int f0;
            f0 = frames;
            do_conv(22'h3FFFFF, -1);          // R7 timeout
            chk(timeout_err, "R7 error set", timeout_err, 1);
            chk(frames == f0, "R7 no frame", frames, f0);
            chk(conv_data == 22'h15B3C9, "R8 conv hold", conv_data, 22'h15B3C9);
        end

        // R7 error cleared at next accept; R8 request while busy ignored
        exp_q.push_back({5'b10001, 9'h010, 8'h00});
        exp_q.push_back(22'h0);
        issue(2'd1, 9'h010, 8'h00);
        chk(!timeout_err, "R7 error cleared", timeout_err, 0);
        repeat (20) @(negedge clk);
        req = 1'b1; req_op = 2'd0; req_addr = 9'h055; req_wdata = 8'h33;
        @(negedge clk);
        req = 1'b0;
        finish_seq();
        chk(rd_data == 8'h0F, "R2 read after abort", rd_data, 8'h0F);
        do_read(9'h055, 8'h00);               // R8 ignored write left no trace
        chk(exp_q.size() == 0, "R8 frames all seen", exp_q.size(), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule